// File: doc/BRIEF.md
# Saturating Proportional-Integral Loop Filter

This block is the digital loop filter of an all-digital phase-locked loop. Each time a new signed phase-error sample arrives with its valid strobe, it adds the sample into a signed integral accumulator. It then forms a proportional-plus-integral sum and registers a new unsigned control word for the oscillator. All gains are powers of two, so the block uses bit selection and needs no multipliers. Every addition clamps at the end of its range instead of wrapping, so a long run of one-signed error cannot flip the loop's correction.

The upper bits of the accumulator are the ones whose upset would knock the loop out of lock. They are kept in three copies, and each bit is read through a two-of-three majority vote. A fault-injection port flips chosen bits of one copy, so the upset tolerance can be exercised. Each accumulator update writes the voted value back to all three copies, which repairs a single corrupted copy.

Top module: `pi_loop_filter`

## Requirements
- R1: While reset is asserted and after its release, the accumulator is zero and `ctrlWord` is mid-scale, 512.
- R2: `ctrlWord` changes only on the clock edge at which `errValid` is high, and it carries that update from the same edge onward. While `errValid` is low, `ctrlWord` holds, whatever `errIn` does.
- R3: On an update with error e (signed, 10 bits), the accumulator A becomes A+e. The integral term is then the new A with its 5 low bits discarded (floor of A/32, 11 bits signed). The proportional term is e at unity gain.
- R4: The 16-bit signed accumulator clamps to 32767 on overflow and to -32768 on underflow. It never wraps.
- R5: The 11-bit sum of the proportional and integral terms clamps to 1023 or -1024. The sum is then halved by dropping its least significant bit, which rounds toward minus infinity.
- R6: The signed 10-bit halved value h is output as offset binary: `ctrlWord` = h+512, which is h with its bit 9 inverted. The range is 0 to 1023.
- R7: A fault applied to one copy (`faultEn` high, `faultCopy` 0, 1 or 2, `faultMask` giving the bits to flip in accumulator bits 15..6) does not change any later `ctrlWord`. A `faultCopy` value of 3 selects no copy and has no effect.
- R8: Every update writes the voted accumulator into all three copies. Faults in the same bit that hit two different copies, with an update between them, still leave the output unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| errIn | input | 10 | Signed phase error |
| errValid | input | 1 | High for one cycle per error sample |
| faultEn | input | 1 | Apply the fault mask on this edge |
| faultCopy | input | 2 | Copy to corrupt (0..2; 3 selects none) |
| faultMask | input | 10 | Bits of accumulator 15..6 to flip |
| ctrlWord | output | 10 | Unsigned oscillator control word |

## Verification
On every cycle, the assertions check the mid-scale reset value and that the output register holds between samples. They also check that the accumulator moves only in the direction of the error's sign, which catches any wrap, and that a single-copy fault leaves the voted accumulator unchanged. Only the bench scenarios can show the exact arithmetic: the floor behaviour of the discarded bits, both saturation points with their recovery, and the offset-binary mapping. The same holds for the write-back repair, which shows only when two faults on different copies straddle an update.

// File: rtl/pi_lf_pkg.sv
package pi_lf_pkg;
  localparam int NUM_COPIES = 3;

  typedef struct packed {
    logic                  update;
    logic [NUM_COPIES-1:0] injectHot;
  } lfStrobes_t;
endpackage

// File: rtl/pi_lf_sat_add.sv
module pi_lf_sat_add #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut
);
  localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_MIN = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] rawSum;
  logic             overUp;
  logic             overDown;

  always_comb begin
    rawSum   = opA + opB;
    overUp   = !opA[WIDTH-1] && !opB[WIDTH-1] &&  rawSum[WIDTH-1];
    overDown =  opA[WIDTH-1] &&  opB[WIDTH-1] && !rawSum[WIDTH-1];
    if (overUp)        sumOut = POS_MAX;
    else if (overDown) sumOut = NEG_MIN;
    else               sumOut = rawSum;
  end
endmodule

// File: rtl/pi_lf_vote_reg.sv
module pi_lf_vote_reg
  import pi_lf_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  loadEn,
  input  logic [WIDTH-1:0]      dIn,
  input  logic [NUM_COPIES-1:0] injectHot,
  input  logic [WIDTH-1:0]      injectMask,
  output logic [WIDTH-1:0]      voted
);
  logic [WIDTH-1:0] copyQ [NUM_COPIES];

  for (genvar k = 0; k < NUM_COPIES; k++) begin : gCopy
    logic [WIDTH-1:0] base;
    assign base = loadEn ? dIn : copyQ[k];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) copyQ[k] <= '0;
      else       copyQ[k] <= base ^ (injectHot[k] ? injectMask : '0);
    end
  end

  assign voted = (copyQ[0] & copyQ[1]) | (copyQ[0] & copyQ[2]) | (copyQ[1] & copyQ[2]);
endmodule

// File: rtl/pi_lf_ctrl.sv
module pi_lf_ctrl
  import pi_lf_pkg::*;
(
  input  logic       errValid,
  input  logic       faultEn,
  input  logic [1:0] faultCopy,
  output lfStrobes_t strobes
);
  always_comb begin
    strobes.update = errValid;
    for (int k = 0; k < NUM_COPIES; k++)
      strobes.injectHot[k] = faultEn && (int'(faultCopy) == k);
  end
endmodule

// File: rtl/pi_lf_datapath.sv
module pi_lf_datapath
  import pi_lf_pkg::*;
#(
  parameter int ERR_W    = 10,
  parameter int ACC_W    = 16,
  parameter int VOTE_W   = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  lfStrobes_t         strobes,
  input  logic [ERR_W-1:0]   errIn,
  input  logic [VOTE_W-1:0]  faultMask,
  output logic [ACC_W-1:0]   accNow,
  output logic [ERR_W:0]     outReg
);
  localparam int SUM_W = ERR_W + 1;
  localparam int LOW_W = ACC_W - VOTE_W;

  logic [ACC_W-1:0] errWide;
  logic [ACC_W-1:0] accNext;
  logic [SUM_W-1:0] propTerm;
  logic [SUM_W-1:0] intTerm;
  logic [SUM_W-1:0] sumSat;
  logic [VOTE_W-1:0] hiVoted;
  logic [LOW_W-1:0]  loQ;

  assign errWide  = {{(ACC_W-ERR_W){errIn[ERR_W-1]}}, errIn};
  assign propTerm = {errIn[ERR_W-1], errIn};
  assign accNow   = {hiVoted, loQ};

  pi_lf_sat_add #(.WIDTH(ACC_W)) uAccAdd (
    .opA(accNow), .opB(errWide), .sumOut(accNext)
  );

  assign intTerm = accNext[ACC_W-1 -: SUM_W];

  pi_lf_sat_add #(.WIDTH(SUM_W)) uSumAdd (
    .opA(propTerm), .opB(intTerm), .sumOut(sumSat)
  );

  pi_lf_vote_reg #(.WIDTH(VOTE_W)) uHiBits (
    .clk(clk), .rstN(rstN), .loadEn(strobes.update),
    .dIn(accNext[ACC_W-1 -: VOTE_W]), .injectHot(strobes.injectHot),
    .injectMask(faultMask), .voted(hiVoted)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loQ    <= '0;
      outReg <= '0;
    end else if (strobes.update) begin
      loQ    <= accNext[LOW_W-1:0];
      outReg <= sumSat;
    end
  end
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
  import pi_lf_pkg::*;
#(
  parameter int ERR_W  = 10,
  parameter int ACC_W  = 16,
  parameter int VOTE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ERR_W-1:0]  errIn,
  input  logic              errValid,
  input  logic              faultEn,
  input  logic [1:0]        faultCopy,
  input  logic [VOTE_W-1:0] faultMask,
  output logic [ERR_W-1:0]  ctrlWord
);
  lfStrobes_t       strobes;
  logic [ACC_W-1:0] accNow;
  logic [ERR_W:0]   outReg;

  pi_lf_ctrl uCtrl (
    .errValid(errValid), .faultEn(faultEn), .faultCopy(faultCopy), .strobes(strobes)
  );

  pi_lf_datapath #(.ERR_W(ERR_W), .ACC_W(ACC_W), .VOTE_W(VOTE_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .errIn(errIn),
    .faultMask(faultMask), .accNow(accNow), .outReg(outReg)
  );

  assign ctrlWord = {~outReg[ERR_W], outReg[ERR_W-1:1]};
endmodule

// File: rtl/pi_lf_checker.sv
module pi_lf_checker #(
  parameter int ERR_W = 10,
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [ERR_W-1:0] errIn,
  input logic             errValid,
  input logic             faultEn,
  input logic [ERR_W-1:0] ctrlWord,
  input logic [ACC_W-1:0] accNow,
  input logic [ERR_W:0]   outReg
);
  localparam logic [ERR_W-1:0] MID = {1'b1, {(ERR_W-1){1'b0}}};

  AST_RESET_MID: assert property (@(posedge clk) !rstN |=> ctrlWord == MID); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !errValid |=> $stable(outReg)); // R2

  AST_ACC_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rstN)
    errValid && !errIn[ERR_W-1] |=> $signed(accNow) >= $signed($past(accNow))); // R4

  AST_ACC_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rstN)
    errValid && errIn[ERR_W-1] |=> $signed(accNow) <= $signed($past(accNow))); // R4

  AST_FAULT_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    faultEn && !errValid |=> $stable(accNow)); // R7
endmodule

bind pi_loop_filter pi_lf_checker #(.ERR_W(ERR_W), .ACC_W(ACC_W)) uChk (
  .clk(clk), .rstN(rstN), .errIn(errIn), .errValid(errValid), .faultEn(faultEn),
  .ctrlWord(ctrlWord), .accNow(accNow), .outReg(outReg)
);

// File: tb/tb_pi_loop_filter.sv
module tb_pi_loop_filter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] errIn = '0;
  logic       errValid = 1'b0;
  logic       faultEn = 1'b0;
  logic [1:0] faultCopy = '0;
  logic [9:0] faultMask = '0;
  logic [9:0] ctrlWord;

  int nChecks = 0;
  int nFails  = 0;
  int accModel = 0;
  int expWord = 512;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pi_loop_filter dut (
    .clk(clk), .rstN(rstN), .errIn(errIn), .errValid(errValid),
    .faultEn(faultEn), .faultCopy(faultCopy), .faultMask(faultMask), .ctrlWord(ctrlWord)
  );

  function automatic int sat(int v, int w);
    int hi = (1 << (w - 1)) - 1;
    int lo = -(1 << (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; errValid = 1'b0; faultEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    accModel = 0;
    expWord = 512;
  endtask

  task automatic applyErr(int e, string req);
    int it;
    int s;
    @(negedge clk);
    errIn = 10'(e); errValid = 1'b1;
    check({req, " pre-edge hold"}, int'(ctrlWord), expWord);
    @(negedge clk);
    errValid = 1'b0;
    accModel = sat(accModel + e, 16);
    it = accModel >>> 5;
    s = sat(e + it, 11);
    expWord = (s >>> 1) + 512;
    check(req, int'(ctrlWord), expWord);
  endtask

  task automatic injectFault(int copy, logic [9:0] mask);
    @(negedge clk);
    faultEn = 1'b1; faultCopy = 2'(copy); faultMask = mask;
    @(negedge clk);
    faultEn = 1'b0;
  endtask

  task automatic tReset();
    doReset();
    check("R1 reset mid-scale", int'(ctrlWord), 512);
    applyErr(0, "R1 accumulator zero after reset");
  endtask

  task automatic tArith();
    doReset();
    applyErr(0,    "R6 zero error mid-scale");
    applyErr(-1,   "R6 minus one below mid-scale");
    applyErr(100,  "R3 proportional plus integral");
    applyErr(-200, "R3 negative step");
    applyErr(37,   "R3 odd sum floor R5");
    applyErr(511,  "R3 max positive error");
    applyErr(-512, "R6 most negative error");
  endtask

  task automatic tHold();
    doReset();
    applyErr(250, "R2 load");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      errIn = 10'(i * 97 - 300);
      check("R2 hold without valid", int'(ctrlWord), expWord);
    end
  endtask

  task automatic tSaturate();
    doReset();
    for (int i = 0; i < 70; i++) applyErr(511, "R4 R5 positive saturation");
    check("R5 output clamps high", int'(ctrlWord), 1023);
    applyErr(-1, "R4 no wrap after upper clamp");
    for (int i = 0; i < 140; i++) applyErr(-512, "R4 R5 negative saturation");
    check("R5 output clamps low", int'(ctrlWord), 0);
    applyErr(1, "R4 no wrap after lower clamp");
  endtask

  task automatic tFault();
    doReset();
    repeat (3) applyErr(300, "R7 build accumulator");
    injectFault(1, 10'h3FF);
    check("R7 idle after fault", int'(ctrlWord), expWord);
    applyErr(0, "R7 single copy fault masked");
    injectFault(3, 10'h3FF);
    injectFault(3, 10'h155);
    applyErr(5, "R7 copy index 3 ignored");
    injectFault(0, 10'h2AA);
    applyErr(0, "R8 first fault then update");
    injectFault(2, 10'h2AA);
    applyErr(0, "R8 second copy same bits after write-back");
    injectFault(1, 10'h2AA);
    applyErr(-7, "R8 third copy same bits after write-back");
  endtask

  initial begin
    tReset();
    tArith();
    tHold();
    tSaturate();
    tFault();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule